// File: doc/BRIEF.md
# Programmable CRC32 Register Peripheral

This block is a CRC accelerator on a plain 32-bit register bus. Software sets a starting value and a 32-bit generator, then sets a load bit in the control register. That load bit copies the starting value into the running checksum. Data is then pushed through the data register, one byte or one full word per write. Each write folds its bits into the checksum in the cycle the write is accepted, so writes can follow each other on consecutive cycles.

Reading the data register returns the checksum computed so far. Software can save that value and later program it as the starting value to pick up an interrupted computation. The control register selects how the input bits are reversed, either inside each byte or across the whole word. A separate control bit reverses the bits of the value returned on reads. With those two options, reflected checksums such as CRC-32 and CRC-32C come out directly. Software applies any final inversion itself.

Top module: `crc32_engine`

## Requirements
- R1: After reset, the control register reads 0, the start value reads 0xFFFFFFFF, the generator reads 0x04C11DB7 and the data register reads 0xFFFFFFFF.
- R2: A control write (offset 0x08, byte enable 0 set) with bit 0 = 1 copies the start value into the running checksum in that cycle. Bit 0 always reads back as 0.
- R3: A data write (offset 0x00) with all four byte enables set folds 32 bits into the checksum in one clock. Bit 31 goes first and each step is: feedback = crc[31] xor d; crc = (crc << 1) xor (feedback ? generator : 0). Consecutive writes need no idle cycle.
- R4: A data write with exactly one byte enable set folds in 8 bits: the byte in that lane (lane k = bits 8k+7..8k), msb first. A data write with any other byte-enable pattern leaves the checksum unchanged.
- R5: Control bits 6:5 set the word input order. 00 feeds the word as is. 01 reverses the bits inside each byte. 11 reverses all 32 bits. 10 acts like 00.
- R6: For byte writes, a 1 in control bit 5 reverses the 8 bits of the byte before it is folded in.
- R7: When control bit 7 is 1, data-register reads return the checksum with bit i moved to bit 31-i. When it is 0, reads return the checksum unchanged.
- R8: The generator register (offset 0x14) is fully writable. With the reflected setup (control 0xA1), feeding the nine ASCII bytes "123456789" and inverting the read gives 0xCBF43926 for generator 0x04C11DB7 and 0xE3069283 for generator 0x1EDC6F41.
- R9: Writes to the start value (0x10), the generator (0x14) and the control register update only the byte lanes whose enables are set. The control register lives in lane 0.
- R10: If a saved checksum is written as the start value and loaded, further data gives the same result as an uninterrupted run.
- R11: Offsets 0x04, 0x0C, 0x18 and 0x1C read 0, and writes to them change nothing. In the control register only bits 7:5 read back. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one access per cycle while high |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; bits 1:0 ignored |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte-lane enables for writes |
| busRdata | output | 32 | Read data, valid in the same cycle as a read access, 0 otherwise |

## Verification
The word path is swept with arithmetic patterns under all four input-order codes. This separates byte-wise reversal from whole-word reversal and confirms that the reserved code acts like none. The byte path is fed all 256 values, rotated across the four lanes, under each reversal setting. A wrong lane select or a missing byte reversal shows up there. Known check values for the two standard generators pin down the bit order against an outside reference. Further tests cover malformed byte enables, partial register writes, unmapped offsets and a save/reload resume, which catch decode and state-keeping faults.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W  = 32;
  localparam int LANES  = CRC_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [CRC_W-1:0] INIT_RST = '1;
  localparam logic [CRC_W-1:0] POLY_RST = 32'h04C11DB7;

  typedef enum logic [1:0] {
    REV_NONE = 2'b00,
    REV_BYTE = 2'b01,
    REV_RSVD = 2'b10,
    REV_WORD = 2'b11
  } inRev_e;

  typedef struct packed {
    logic              loadInit;
    logic              feedWord;
    logic              feedByte;
    logic [LANE_W-1:0] lane;
  } crcStrobe_t;

  function automatic logic [CRC_W-1:0] revBits(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  function automatic logic [7:0] revByte(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // Folds the top nBits of din (left aligned) into crc, msb first.
  function automatic logic [CRC_W-1:0] crcShift(input logic [CRC_W-1:0] crc,
                                                input logic [CRC_W-1:0] din,
                                                input int nBits,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc;
    for (int i = 0; i < CRC_W; i++) begin
      if (i < nBits) begin
        fb = c[CRC_W-1] ^ din[CRC_W-1-i];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CRC_W-1:0]  busWdata,
  input  logic [LANES-1:0]  busBe,
  input  logic [CRC_W-1:0]  crcRead,
  output logic [CRC_W-1:0]  busRdata,
  output crcStrobe_t        strb,
  output logic [CRC_W-1:0]  initVal,
  output logic [CRC_W-1:0]  polyVal,
  output logic [1:0]        inMode,
  output logic              outRev
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CTL  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_INIT = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_POLY = IDX_W'(5);

  logic [IDX_W-1:0] wIdx;
  logic             wrEn, rdEn;
  logic [1:0]       modeQ;
  logic             outRevQ;
  logic [CRC_W-1:0] initQ, polyQ;
  logic [LANE_W-1:0] laneEnc;

  assign wIdx = busAddr[ADDR_W-1:2];
  assign wrEn = busSel & busWrite;
  assign rdEn = busSel & ~busWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 2'b00;
      outRevQ <= 1'b0;
    end else if (wrEn && wIdx == IDX_CTL && busBe[0]) begin
      modeQ   <= busWdata[6:5];
      outRevQ <= busWdata[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initQ <= INIT_RST;
      polyQ <= POLY_RST;
    end else if (wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (busBe[l] && wIdx == IDX_INIT) initQ[8*l +: 8] <= busWdata[8*l +: 8];
        if (busBe[l] && wIdx == IDX_POLY) polyQ[8*l +: 8] <= busWdata[8*l +: 8];
      end
    end
  end

  always_comb begin
    laneEnc = '0;
    for (int l = 0; l < LANES; l++)
      if (busBe[l]) laneEnc = LANE_W'(l);
  end

  always_comb begin
    strb          = '0;
    strb.loadInit = wrEn && wIdx == IDX_CTL && busBe[0] && busWdata[0];
    strb.feedWord = wrEn && wIdx == IDX_DATA && (busBe == '1);
    strb.feedByte = wrEn && wIdx == IDX_DATA && $onehot(busBe);
    strb.lane     = laneEnc;
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      case (wIdx)
        IDX_DATA: busRdata = crcRead;
        IDX_CTL: begin
          busRdata[7]   = outRevQ;
          busRdata[6:5] = modeQ;
        end
        IDX_INIT: busRdata = initQ;
        IDX_POLY: busRdata = polyQ;
        default:  busRdata = '0;
      endcase
    end
  end

  assign initVal = initQ;
  assign polyVal = polyQ;
  assign inMode  = modeQ;
  assign outRev  = outRevQ;
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobe_t       strb,
  input  logic [CRC_W-1:0] wData,
  input  logic [CRC_W-1:0] initVal,
  input  logic [CRC_W-1:0] polyVal,
  input  logic [1:0]       inMode,
  input  logic             outRev,
  output logic [CRC_W-1:0] crcState,
  output logic [CRC_W-1:0] crcRead
);
  logic [CRC_W-1:0] crcQ, wordIn, nextWord, nextByte;
  logic [7:0]       byteSel, byteIn;

  always_comb begin
    case (inMode)
      REV_BYTE: for (int l = 0; l < LANES; l++) wordIn[8*l +: 8] = revByte(wData[8*l +: 8]);
      REV_WORD: wordIn = revBits(wData);
      default:  wordIn = wData;
    endcase
  end

  assign byteSel  = wData[8*strb.lane +: 8];
  assign byteIn   = inMode[0] ? revByte(byteSel) : byteSel;
  assign nextWord = crcShift(crcQ, wordIn, CRC_W, polyVal);
  assign nextByte = crcShift(crcQ, {byteIn, {(CRC_W-8){1'b0}}}, 8, polyVal);

  always_ff @(posedge clk) begin
    if (!rstN)              crcQ <= INIT_RST;
    else if (strb.loadInit) crcQ <= initVal;
    else if (strb.feedWord) crcQ <= nextWord;
    else if (strb.feedByte) crcQ <= nextByte;
  end

  assign crcState = crcQ;
  assign crcRead  = outRev ? revBits(crcQ) : crcQ;
endmodule

// File: rtl/crc32_engine.sv
module crc32_engine
  import crc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [3:0]        busBe,
  output logic [31:0]       busRdata
);
  crcStrobe_t       strb;
  logic [CRC_W-1:0] initVal, polyVal, crcState, crcRead;
  logic [1:0]       inMode;
  logic             outRev;

  crc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busBe(busBe),
    .crcRead(crcRead), .busRdata(busRdata), .strb(strb),
    .initVal(initVal), .polyVal(polyVal), .inMode(inMode), .outRev(outRev)
  );

  crc_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(busWdata),
    .initVal(initVal), .polyVal(polyVal), .inMode(inMode), .outRev(outRev),
    .crcState(crcState), .crcRead(crcRead)
  );
endmodule

// File: rtl/crc_checker.sv
module crc_checker
  import crc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busBe,
  input logic [31:0]       busRdata,
  input crcStrobe_t        strb,
  input logic [31:0]       crcState,
  input logic [31:0]       initVal,
  input logic              outRev
);
  logic [ADDR_W-3:0] idx;
  logic mapped, rdAcc, wrAcc;
  assign idx    = busAddr[ADDR_W-1:2];
  assign mapped = (idx == 0) || (idx == 2) || (idx == 4) || (idx == 5);
  assign rdAcc  = busSel && !busWrite;
  assign wrAcc  = busSel && busWrite;

  AST_CTL_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && idx == 2) |-> (busRdata[4:0] == 5'b0)); // R2

  AST_LOAD_TAKES_INIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadInit |=> (crcState == $past(initVal))); // R2

  AST_BAD_BE_NO_FEED: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && idx == 0 && !$onehot(busBe) && busBe != 4'hF) |=> $stable(crcState)); // R4

  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && idx == 0) |-> (busRdata == (outRev ? revBits(crcState) : crcState))); // R7

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && !mapped) |-> (busRdata == 32'h0)); // R11

  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && !mapped) |=> ($stable(crcState) && $stable(initVal))); // R11
endmodule

bind crc32_engine crc_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busBe(busBe), .busRdata(busRdata), .strb(strb),
  .crcState(crcState), .initVal(initVal), .outRev(outRev)
);

// File: tb/tb_crc32_engine.sv
module tb_crc32_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busRdata;
  int errs = 0, checks = 0;
  bit done = 0;

  crc32_engine #(.ADDR_W(5)) dut (.*);

  always #2 clk = ~clk;

  localparam logic [4:0] A_DATA = 5'h00, A_CTL = 5'h08, A_INIT = 5'h10, A_POLY = 5'h14;
  localparam logic [31:0] P32 = 32'h04C11DB7, P32C = 32'h1EDC6F41;

  function automatic logic [31:0] refBit(input logic [31:0] c, input logic b, input logic [31:0] p);
    return (c[31] ^ b) ? ((c << 1) ^ p) : (c << 1);
  endfunction

  function automatic logic [31:0] refWord(input logic [31:0] c, input logic [31:0] w,
                                          input logic [1:0] m, input logic [31:0] p);
    if (m == 2'b01) begin
      for (int j = 3; j >= 0; j--) for (int i = 0; i < 8; i++) c = refBit(c, w[8*j+i], p);
    end else if (m == 2'b11) begin
      for (int i = 0; i < 32; i++) c = refBit(c, w[i], p);
    end else begin
      for (int i = 31; i >= 0; i--) c = refBit(c, w[i], p);
    end
    return c;
  endfunction

  function automatic logic [31:0] refByte(input logic [31:0] c, input logic [7:0] b,
                                          input logic [1:0] m, input logic [31:0] p);
    if (m[0]) for (int i = 0; i < 8; i++) c = refBit(c, b[i], p);
    else      for (int i = 7; i >= 0; i--) c = refBit(c, b[i], p);
    return c;
  endfunction

  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busBe = be;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busBe = '0;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic feedByte(input logic [7:0] b, input int lane);
    wr(A_DATA, 32'(b) << (8*lane), 4'(1 << lane));
  endtask

  task automatic feedAscii(input logic [31:0] p, output logic [31:0] res);
    string s = "123456789";
    wr(A_POLY, p, 4'hF);
    wr(A_INIT, 32'hFFFFFFFF, 4'hF);
    wr(A_CTL, 32'hA1, 4'hF);
    for (int i = 0; i < 9; i++) feedByte(s[i], i % 4);
    rd(A_DATA, res);
  endtask

  initial begin
    #(4 * 150000);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] got, exp, saved, ref0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(A_CTL, got);  chk("R1 ctl", got, 32'h0);
    rd(A_INIT, got); chk("R1 init", got, 32'hFFFFFFFF);
    rd(A_POLY, got); chk("R1 poly", got, P32);
    rd(A_DATA, got); chk("R1 data", got, 32'hFFFFFFFF);

    // R8 standard check values
    feedAscii(P32, got);  chk("R8 crc32 check", ~got, 32'hCBF43926);
    feedAscii(P32C, got); chk("R8 crc32c check", ~got, 32'hE3069283);
    wr(A_POLY, P32, 4'hF);

    // R5 word paths reaching the same check value
    wr(A_CTL, 32'hA1, 4'hF);
    wr(A_DATA, 32'h31323334, 4'hF); wr(A_DATA, 32'h35363738, 4'hF); feedByte("9", 0);
    rd(A_DATA, got); chk("R5 byte-rev words", ~got, 32'hCBF43926);
    wr(A_CTL, 32'hE1, 4'hF);
    wr(A_DATA, 32'h34333231, 4'hF); wr(A_DATA, 32'h38373635, 4'hF); feedByte("9", 2);
    rd(A_DATA, got); chk("R5 word-rev words", ~got, 32'hCBF43926);

    // R3 R5 word sweep, back-to-back pairs, all input order codes
    for (int m = 0; m < 4; m++) begin
      wr(A_CTL, 32'((m << 5) | 1), 4'hF);
      exp = 32'hFFFFFFFF;
      for (int k = 0; k < 8; k++) begin
        logic [31:0] w0, w1;
        w0 = 32'h9E3779B9 * 32'(k + 1 + 8*m);
        w1 = ~w0 ^ (32'h01010101 << (k % 8));
        wr(A_DATA, w0, 4'hF); wr(A_DATA, w1, 4'hF);
        exp = refWord(refWord(exp, w0, 2'(m), P32), w1, 2'(m), P32);
        rd(A_DATA, got); chk("R3 R5 word sweep", got, exp);
      end
    end

    // R4 R6 byte sweep over all values and lanes
    for (int mi = 0; mi < 3; mi++) begin
      logic [1:0] m;
      m = (mi == 0) ? 2'b00 : (mi == 1) ? 2'b01 : 2'b11;
      wr(A_CTL, 32'(({30'b0, m} << 5) | 1), 4'hF);
      exp = 32'hFFFFFFFF;
      for (int v = 0; v < 256; v++) begin
        feedByte(8'(v), v % 4);
        exp = refByte(exp, 8'(v), m, P32);
        if (v % 32 == 31) begin
          rd(A_DATA, got); chk("R4 R6 byte sweep", got, exp);
        end
      end
    end

    // R4 malformed byte enables leave the checksum alone
    rd(A_DATA, saved);
    wr(A_DATA, 32'hDEADBEEF, 4'b0011);
    wr(A_DATA, 32'hDEADBEEF, 4'b0000);
    wr(A_DATA, 32'hDEADBEEF, 4'b1110);
    rd(A_DATA, got); chk("R4 bad enables ignored", got, saved);

    // R7 output reversal
    wr(A_CTL, 32'h01, 4'hF);
    wr(A_DATA, 32'h0000_0001, 4'hF);
    exp = refWord(32'hFFFFFFFF, 32'h1, 2'b00, P32);
    rd(A_DATA, got); chk("R7 plain read", got, exp);
    wr(A_CTL, 32'h80, 4'hF);
    rd(A_DATA, got); chk("R7 reversed read", got, flip(exp));

    // R10 save and resume
    wr(A_CTL, 32'h01, 4'hF);
    ref0 = 32'hFFFFFFFF;
    for (int k = 0; k < 3; k++) begin
      wr(A_DATA, 32'h1234_5678 + 32'(k * 32'h1111), 4'hF);
      ref0 = refWord(ref0, 32'h1234_5678 + 32'(k * 32'h1111), 2'b00, P32);
    end
    rd(A_DATA, saved);
    wr(A_DATA, 32'hCAFEF00D, 4'hF);
    wr(A_INIT, saved, 4'hF);
    wr(A_CTL, 32'h01, 4'hF);
    wr(A_DATA, 32'hA5A5_0F0F, 4'hF); feedByte(8'h3C, 3);
    ref0 = refByte(refWord(ref0, 32'hA5A5_0F0F, 2'b00, P32), 8'h3C, 2'b00, P32);
    rd(A_DATA, got); chk("R10 resumed result", got, ref0);

    // R9 partial register writes
    wr(A_INIT, 32'hAABBCCDD, 4'b0100);
    rd(A_INIT, got); chk("R9 init lane 2", got, (saved & 32'hFF00FFFF) | 32'h00BB0000);
    wr(A_POLY, 32'h000000AA, 4'b0001);
    rd(A_POLY, got); chk("R9 poly lane 0", got, 32'h04C11DAA);
    wr(A_POLY, P32, 4'hF);
    rd(A_DATA, saved);
    wr(A_CTL, 32'hA1, 4'b1110);
    rd(A_CTL, got);  chk("R9 ctl lane 0 disabled", got, 32'h0);
    rd(A_DATA, got); chk("R9 no load without lane 0", got, saved);

    // R11 unmapped offsets and unused control bits
    wr(5'h04, 32'h12345678, 4'hF);
    wr(5'h18, 32'h12345678, 4'hF);
    rd(5'h04, got); chk("R11 read 0x04", got, 32'h0);
    rd(5'h0C, got); chk("R11 read 0x0C", got, 32'h0);
    rd(5'h1C, got); chk("R11 read 0x1C", got, 32'h0);
    rd(A_DATA, got); chk("R11 crc untouched", got, saved);
    rd(A_INIT, exp);
    wr(A_CTL, 32'hFFFFFFFF, 4'hF);
    rd(A_CTL, got);  chk("R11 R2 ctl readback", got, 32'hE0);
    rd(A_DATA, got); chk("R2 load via full write", got, flip(exp));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule